// File: doc/BRIEF.md
# Channel-Indexed DMA Control Register Bank

This block is the software-visible register file of a multi-channel DMA engine. A host reaches it through a plain 32-bit bus: a write strobe, an 8-bit byte offset, write data and read data. There are twenty channels, but they all share one window of per-channel offsets. A channel-select register decides which channel's control, polling, descriptor-base, descriptor-count, interrupt-status and interrupt-enable registers that window reaches. A port-select register does the same for a small set of per-port control words. The block also holds the global registers: an engine reset, a read-only identification word and a mask that enables interrupts per channel.

Each channel can be reset through its control register. The reset request bit reads back as set until an internal countdown of fixed length expires. Software polls the bit until it reads zero. When the countdown ends, the bit clears, the channel is switched off and its interrupt status is wiped.

Each channel has a completion strobe input that sets its descriptor-complete status bit. A single interrupt output combines every channel whose enabled status bit is pending and whose bit is set in the global mask. Read data is a combinational function of the offset and the register state.

Top module: `dma_regbank`

## Requirements
- R1: Offset 0x08 reads a constant identification word. Bits 4:0 hold the revision (default 3), bits 19:16 hold the port count (default 4), bits 31:20 hold the channel count (default 20) and all other bits are 0. With the defaults it reads 0x01440003.
- R2: A write to the channel-select register at 0x18 with a value below the channel count selects that channel for offsets 0x14 to 0x2C. A write of the channel count or more leaves the selection unchanged. Each channel keeps its own values.
- R3: Channel control at 0x1C stores the on bit (bit 0), the transmit bit (bit 8) and a 2-bit weight (bits 17:16). All other bits read 0.
- R4: Writing 1 to channel control bit 1 makes that bit read 1 for exactly RST_CYC cycles (default 8) after the write edge. It then reads 0, and in the same cycle the channel's on bit and all of its status bits become 0.
- R5: Descriptor base at 0x20 stores 32 bits. Descriptor count at 0x24 stores its low 8 bits, and the upper bits read 0.
- R6: A one-cycle pulse on desc_done[n] sets bit 3 of channel n's interrupt status, which is read at 0x28.
- R7: Writing to 0x28 clears each status bit of the selected channel that is 1 in both the write data and 0x7E.
- R8: irq is 1 exactly when some channel n has a status bit that is also set in its enable register at 0x2C, and bit n of the mask at 0xF4 is 1.
- R9: The interrupt mask at 0xF4 holds one bit per channel, bit n for channel n, and reads back what was written.
- R10: Writing with bit 0 set to global control at 0x10 zeroes every register of every channel in the next cycle. This includes any reset countdown in progress. Offset 0x10 always reads 0.
- R11: The channel poll register at 0x14 stores bit 31 (poll enable) and bit 6 (divide-by-4). All other bits read 0.
- R12: Port select at 0x40 accepts values below the port count and ignores larger ones. Port control at 0x44 stores bits 11:8, 6 and 5:2 of the selected port, and all other bits read 0.
- R13: After the synchronous reset every register reads 0 except the identification word. Unmapped offsets always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the current offset |
| addr | input | 8 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr, combinational |
| desc_done | input | 20 | Per-channel descriptor-complete strobes |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench checks that a channel-select value that is out of range is dropped. A design that took it would alias the per-channel window onto a random channel, and a following descriptor-base read would show another channel's value. The channel-reset bit is sampled on the last cycle it must still read 1 and on the first cycle it must read 0. A counter that is off by one, or that forgets to clear the on bit or the status, fails there. The interrupt is checked against each of its three conditions, so a design that ignored the global mask or the per-channel enable would raise irq when it should stay low. The write-1-to-clear path and the engine reset are observed through reads of the status and descriptor registers.

// File: rtl/dma_rb_pkg.sv
package dma_rb_pkg;

    localparam int LEN_W = 8;
    localparam int STS_W = 8;
    localparam int DONE_BIT = 3;

    localparam logic [7:0] OFF_ID    = 8'h08;
    localparam logic [7:0] OFF_GCTRL = 8'h10;
    localparam logic [7:0] OFF_POLL  = 8'h14;
    localparam logic [7:0] OFF_CSEL  = 8'h18;
    localparam logic [7:0] OFF_CTRL  = 8'h1C;
    localparam logic [7:0] OFF_BASE  = 8'h20;
    localparam logic [7:0] OFF_LEN   = 8'h24;
    localparam logic [7:0] OFF_STS   = 8'h28;
    localparam logic [7:0] OFF_IE    = 8'h2C;
    localparam logic [7:0] OFF_PSEL  = 8'h40;
    localparam logic [7:0] OFF_PCTRL = 8'h44;
    localparam logic [7:0] OFF_MASK  = 8'hF4;

    localparam logic [31:0]      PCTRL_KEEP = 32'h0000_0F7C;
    localparam logic [STS_W-1:0] STS_W1C    = 8'h7E;

    typedef struct packed {
        logic [31:0]      base;
        logic [LEN_W-1:0] len;
        logic [STS_W-1:0] sts;
        logic [STS_W-1:0] ie;
        logic [1:0]       weight;
        logic             tx;
        logic             on;
        logic             poll_en;
        logic             poll_div4;
    } chan_regs_t;

    function automatic logic [31:0] ctrl_word(chan_regs_t c, logic busy);
        return 32'({c.weight, 7'b0, c.tx, 6'b0, busy, c.on});
    endfunction

    function automatic logic [31:0] poll_word(chan_regs_t c);
        return {c.poll_en, 24'b0, c.poll_div4, 6'b0};
    endfunction

    function automatic logic [31:0] id_word(int rev, int nport, int nch);
        return {12'(nch), 4'(nport), 11'b0, 5'(rev)};
    endfunction

endpackage

// File: rtl/dma_rb_chan.sv
module dma_rb_chan
    import dma_rb_pkg::*;
#(
    parameter int RST_CYC = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        eng_rst,
    input  logic        wr_ctrl,
    input  logic        wr_poll,
    input  logic        wr_base,
    input  logic        wr_len,
    input  logic        wr_sts,
    input  logic        wr_ie,
    input  logic [31:0] wdata,
    input  logic        done,
    output chan_regs_t  q,
    output logic        busy,
    output logic        irq_req
);

    localparam int CW = $clog2(RST_CYC + 1);

    logic [CW-1:0]    cnt;
    logic             finish;
    logic [STS_W-1:0] sts_n;

    assign busy    = (cnt != '0);
    assign finish  = (cnt == CW'(1));
    assign irq_req = |(q.sts & q.ie);

    always_comb begin
        sts_n = q.sts;
        if (wr_sts) sts_n = sts_n & ~(wdata[STS_W-1:0] & STS_W1C);
        if (done)   sts_n[DONE_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || eng_rst) begin
            q   <= '0;
            cnt <= '0;
        end else begin
            if (wr_ctrl) begin
                q.on     <= wdata[0];
                q.tx     <= wdata[8];
                q.weight <= wdata[17:16];
            end
            if (wr_ctrl && wdata[1] && !busy) cnt <= CW'(RST_CYC);
            else if (busy)                    cnt <= cnt - CW'(1);
            if (wr_poll) begin
                q.poll_en   <= wdata[31];
                q.poll_div4 <= wdata[6];
            end
            if (wr_base) q.base <= wdata;
            if (wr_len)  q.len  <= wdata[LEN_W-1:0];
            if (wr_ie)   q.ie   <= wdata[STS_W-1:0];
            q.sts <= sts_n;
            if (finish) begin
                q.on  <= 1'b0;
                q.sts <= '0;
            end
        end
    end

    // R4: at the end of a channel reset the channel is off and its status is clear
    p_rst_end_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (!q.on && q.sts == '0));

    // R6: a completion strobe sets the descriptor-complete bit
    p_done_sets_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !eng_rst && !finish) |=> q.sts[DONE_BIT]);

    // R7: written ones in the clear field leave those bits at 0
    p_w1c_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_sts && !done && !eng_rst) |=> ((q.sts & $past(wdata[STS_W-1:0]) & STS_W1C) == '0));

    // R10: an engine reset empties the channel
    p_eng_clear_r10: assert property (@(posedge clk) disable iff (rst)
        eng_rst |=> (q == '0 && !busy));

endmodule

// File: rtl/dma_rb_port.sv
module dma_rb_port
    import dma_rb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] q
);

    always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (we) q <= wdata & PCTRL_KEEP;
    end

    // R12: bits outside the kept fields never become set
    p_pctrl_fields_r12: assert property (@(posedge clk) disable iff (rst)
        we |=> ((q & ~PCTRL_KEEP) == '0));

endmodule

// File: rtl/dma_regbank.sv
module dma_regbank
    import dma_rb_pkg::*;
#(
    parameter int NCH     = 20,
    parameter int NPORT   = 4,
    parameter int REV     = 3,
    parameter int RST_CYC = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic [NCH-1:0]   desc_done,
    output logic             irq
);

    localparam int CSW = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int PSW = (NPORT > 1) ? $clog2(NPORT) : 1;
    localparam logic [31:0] ID_VAL = id_word(REV, NPORT, NCH);

    logic [CSW-1:0]  chan_sel;
    logic [PSW-1:0]  port_sel;
    logic [NCH-1:0]  mask;
    chan_regs_t      cr [NCH];
    logic [NCH-1:0]  busy;
    logic [NCH-1:0]  irq_req;
    logic [31:0]     pr [NPORT];
    logic            eng_rst;

    assign eng_rst = wr_en && (addr == OFF_GCTRL) && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            chan_sel <= '0;
            port_sel <= '0;
            mask     <= '0;
        end else if (wr_en) begin
            if (addr == OFF_CSEL && wdata < 32'(NCH))   chan_sel <= wdata[CSW-1:0];
            if (addr == OFF_PSEL && wdata < 32'(NPORT)) port_sel <= wdata[PSW-1:0];
            if (addr == OFF_MASK)                       mask     <= wdata[NCH-1:0];
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        logic hit;
        assign hit = wr_en && (chan_sel == CSW'(i));
        dma_rb_chan #(.RST_CYC(RST_CYC)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .eng_rst (eng_rst),
            .wr_ctrl (hit && addr == OFF_CTRL),
            .wr_poll (hit && addr == OFF_POLL),
            .wr_base (hit && addr == OFF_BASE),
            .wr_len  (hit && addr == OFF_LEN),
            .wr_sts  (hit && addr == OFF_STS),
            .wr_ie   (hit && addr == OFF_IE),
            .wdata   (wdata),
            .done    (desc_done[i]),
            .q       (cr[i]),
            .busy    (busy[i]),
            .irq_req (irq_req[i])
        );
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        dma_rb_port u_port (
            .clk   (clk),
            .rst   (rst),
            .we    (wr_en && addr == OFF_PCTRL && port_sel == PSW'(p)),
            .wdata (wdata),
            .q     (pr[p])
        );
    end

    assign irq = |(irq_req & mask);

    always_comb begin
        case (addr)
            OFF_ID:    rdata = ID_VAL;
            OFF_POLL:  rdata = poll_word(cr[chan_sel]);
            OFF_CSEL:  rdata = 32'(chan_sel);
            OFF_CTRL:  rdata = ctrl_word(cr[chan_sel], busy[chan_sel]);
            OFF_BASE:  rdata = cr[chan_sel].base;
            OFF_LEN:   rdata = 32'(cr[chan_sel].len);
            OFF_STS:   rdata = 32'(cr[chan_sel].sts);
            OFF_IE:    rdata = 32'(cr[chan_sel].ie);
            OFF_PSEL:  rdata = 32'(port_sel);
            OFF_PCTRL: rdata = pr[port_sel];
            OFF_MASK:  rdata = 32'(mask);
            default:   rdata = '0;
        endcase
    end

    // R2: an out-of-range select leaves the selection alone
    p_sel_range_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFF_CSEL && wdata >= 32'(NCH)) |=> $stable(chan_sel));

    // R8: no interrupt without a mask bit
    p_irq_mask_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> (mask != '0));

    // R13: an unmapped offset reads zero
    p_unmapped_r13: assert property (@(posedge clk) disable iff (rst)
        (addr == 8'h00 || addr == 8'hFC) |-> (rdata == '0));

endmodule

// File: tb/sim_dma_regbank.sv
`timescale 1ns/1ps
module sim_dma_regbank;

    localparam int NCH = 20;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic [7:0]      addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NCH-1:0]  desc_done = '0;
    logic            irq;

    dma_regbank u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .desc_done(desc_done), .irq(irq)
    );

    always #2 clk = ~clk;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t sbq[$];
    event  smp;
    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(smp);
            while (sbq.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sbq.pop_front();
                act = it.is_irq ? {31'b0, irq} : rdata;
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic do_wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        addr = a;
        #1;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        sbq.push_back(it);
        -> smp;
        @(negedge clk);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        item_t it;
        #1;
        it.is_irq = 1'b1; it.exp = {31'b0, e}; it.tag = tag;
        sbq.push_back(it);
        -> smp;
        @(negedge clk);
    endtask

    task automatic pulse(input int n);
        desc_done[n] = 1'b1;
        @(negedge clk);
        desc_done = '0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state and identification
        chk_rd(8'h08, 32'h0144_0003, "R1 id word");
        chk_rd(8'h18, 32'h0, "R13 chan select after reset");
        chk_rd(8'h1C, 32'h0, "R13 control after reset");
        chk_rd(8'hF4, 32'h0, "R13 mask after reset");
        chk_irq(1'b0, "R13 irq after reset");
        chk_rd(8'h00, 32'h0, "R13 unmapped 0x00");
        chk_rd(8'h30, 32'h0, "R13 unmapped 0x30");
        chk_rd(8'hFC, 32'h0, "R13 unmapped 0xFC");

        // control fields, base and count on channel 5
        do_wr(8'h18, 32'd5);
        do_wr(8'h1C, 32'hFFFF_FFFD);
        chk_rd(8'h1C, 32'h0003_0101, "R3 control fields");
        do_wr(8'h20, 32'hDEAD_BEEF);
        do_wr(8'h24, 32'h0000_01A3);
        chk_rd(8'h20, 32'hDEAD_BEEF, "R5 base");
        chk_rd(8'h24, 32'h0000_00A3, "R5 count width");
        do_wr(8'h14, 32'hFFFF_FFFF);
        chk_rd(8'h14, 32'h8000_0040, "R11 poll bits");

        // out-of-range select ignored, channels independent
        do_wr(8'h18, 32'd25);
        chk_rd(8'h18, 32'd5, "R2 select 25 ignored");
        do_wr(8'h18, 32'd20);
        chk_rd(8'h20, 32'hDEAD_BEEF, "R2 select 20 ignored");
        do_wr(8'h18, 32'd7);
        chk_rd(8'h20, 32'h0, "R2 channel 7 own base");
        do_wr(8'h20, 32'h0000_1234);
        do_wr(8'h18, 32'd5);
        chk_rd(8'h20, 32'hDEAD_BEEF, "R2 channel 5 kept base");

        // interrupt path on channel 5
        do_wr(8'h2C, 32'h0000_0008);
        do_wr(8'hF4, 32'h0000_0020);
        chk_rd(8'hF4, 32'h0000_0020, "R9 mask readback");
        pulse(5);
        chk_rd(8'h28, 32'h0000_0008, "R6 done sets bit 3");
        chk_irq(1'b1, "R8 irq with enable and mask");
        do_wr(8'hF4, 32'h0);
        chk_irq(1'b0, "R8 irq masked globally");
        do_wr(8'hF4, 32'h0000_0020);
        do_wr(8'h2C, 32'h0);
        chk_irq(1'b0, "R8 irq without channel enable");
        do_wr(8'h2C, 32'h0000_0008);
        chk_irq(1'b1, "R8 irq re-enabled");
        do_wr(8'h28, 32'h0000_0081);
        chk_rd(8'h28, 32'h0000_0008, "R7 clear outside field ignored");
        do_wr(8'h28, 32'h0000_007E);
        chk_rd(8'h28, 32'h0, "R7 write one clears");
        chk_irq(1'b0, "R7 irq after clear");
        pulse(6);
        chk_irq(1'b0, "R8 unenabled channel 6");

        // channel reset countdown on channel 2
        do_wr(8'h18, 32'd2);
        do_wr(8'h2C, 32'h0000_0008);
        do_wr(8'hF4, 32'h0000_0004);
        pulse(2);
        chk_irq(1'b1, "R8 channel 2 pending");
        do_wr(8'h1C, 32'h0000_0003);
        chk_rd(8'h1C, 32'h0000_0003, "R4 reset bit first cycle");
        repeat (6) @(negedge clk);
        chk_rd(8'h1C, 32'h0000_0003, "R4 reset bit last busy cycle");
        chk_rd(8'h1C, 32'h0, "R4 reset done, channel off");
        chk_rd(8'h28, 32'h0, "R4 status wiped");
        chk_irq(1'b0, "R4 irq gone");

        // port registers
        do_wr(8'h40, 32'd1);
        do_wr(8'h44, 32'hFFFF_FFFF);
        chk_rd(8'h44, 32'h0000_0F7C, "R12 port control fields");
        do_wr(8'h40, 32'd9);
        chk_rd(8'h40, 32'd1, "R12 port select 9 ignored");
        do_wr(8'h40, 32'd2);
        chk_rd(8'h44, 32'h0, "R12 port 2 own value");

        // engine reset
        do_wr(8'h18, 32'd5);
        do_wr(8'h1C, 32'h0001_0100);
        do_wr(8'h10, 32'h0000_0001);
        chk_rd(8'h10, 32'h0, "R10 global control reads 0");
        chk_rd(8'h20, 32'h0, "R10 base cleared");
        chk_rd(8'h1C, 32'h0, "R10 control cleared");
        chk_rd(8'h2C, 32'h0, "R10 enable cleared");
        chk_rd(8'h14, 32'h0, "R10 poll cleared");

        finished = 1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

endmodule